// File: doc/BRIEF.md
# Variable Latency Peripheral Bus Controller

This block masters a slow, asynchronous peripheral bus on behalf of an on-chip requester. A single request names a start word address, a direction, a beat count, whether the address advances and the two timing fields (strobe width and inter-beat gap). The controller then runs the whole burst. It asserts chip select, waits a fixed lead, and pulses a separate read or write strobe once per beat. Each beat is held open until a ready line from the peripheral, brought through a synchronizer, is high and the strobe has been low long enough.

Read data comes back to the requester as one-cycle valid pulses, one per beat. Write data and byte enables are pulled from the requester one beat at a time through a take pulse. A write beat whose byte enables are all clear keeps its timing but never pulses the write strobe. Holding the address constant lets the bus reach FIFO-style port devices.

Top module: `vlat_bus_ctrl`

## Requirements
- R1: While reset is active, chip select, output enable and write strobe are high (inactive), every byte select is high, busy is low and rd_valid is low.
- R2: A request seen while idle is accepted at that clock edge. Chip select goes low and busy goes high in the next cycle, and the first strobe goes low exactly two cycles after chip select first goes low.
- R3: Reads pulse bus_oe_n low once per beat, and writes pulse bus_pwe_n low once per beat. A read never drives bus_pwe_n low, a write never drives bus_oe_n low, and no strobe is low while chip select is high.
- R4: bus_rdy passes through a chain of SYNC_STAGES flops (2 in the bench), and only the last flop's value decides beat completion.
- R5: A beat completes at the rising edge where the synchronized ready is high and the strobe has already been low for at least RDF+1 cycles. The strobe rises one cycle after that edge, so with ready high early the strobe is low for exactly RDF+2 cycles.
- R6: For reads, bus_rdata is captured at the completion edge. rd_data carries it while rd_valid is high for exactly one cycle, and that cycle is the strobe's last low cycle.
- R7: Between two beats of one burst the strobe stays high for exactly RDN+2 cycles.
- R8: After the last strobe of a burst rises, chip select and the byte selects stay asserted for exactly one cycle and then release, and busy falls together with chip select.
- R9: bus_addr holds the request address on the first beat. When the increment flag is set it advances by one word (modulo 2^ADDR_W) on each later beat, and otherwise it stays constant. It only changes at the edge where a strobe rises between beats.
- R10: During a write burst bus_bs_n is the bitwise inverse of the current beat's enables (bit i covers data bits 8i+7:8i). During a read burst it is all zeros. A write beat with all enables clear (bus_bs_n all ones) keeps its full timing but leaves bus_pwe_n high.
- R11: RDF and RDN are sampled at acceptance, and changes on cfg_rdf/cfg_rdn during a burst have no effect on that burst.
- R12: req_valid is ignored while busy is high: it causes no second chip-select assertion and no change in the running burst.
- R13: wr_take is high during the accepting cycle of a write and during the cycle before each later write beat's gap starts. At those edges wr_be/wr_data are captured, and bus_wdata then holds that beat's data with bus_wdata_en high for the rest of the write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Beat count minus one |
| req_incr | input | 1 | 1 = address advances per beat |
| cfg_rdf | input | CFG_W | Minimum strobe width field |
| cfg_rdn | input | CFG_W | Inter-beat gap field |
| wr_be | input | DATA_W/8 | Byte enables of the beat being taken, active high |
| wr_data | input | DATA_W | Write data of the beat being taken |
| wr_take | output | 1 | Current wr_be/wr_data consumed at this edge |
| busy | output | 1 | Burst in progress |
| rd_valid | output | 1 | One-cycle read beat valid |
| rd_data | output | DATA_W | Captured read beat |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_pwe_n | output | 1 | Write strobe, active low |
| bus_bs_n | output | DATA_W/8 | Byte selects, active low |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_wdata_en | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_rdy | input | 1 | Asynchronous, level-sensitive ready |

## Verification
The bench builds the block with a 12-bit address, a 16-bit data path (two byte lanes), eight beats at most, 4-bit timing fields and a two-stage synchronizer. The narrow address makes a burst that wraps past the top of the address space reachable in three beats. Two lanes are enough to cover partly masked, fully masked and fully enabled write beats. The 4-bit fields let the extreme settings (zero and fifteen) be run in full, which yields strobes from 2 to 17 cycles long and gaps from 2 to 17 cycles.

// File: rtl/vlat_pkg.sv
package vlat_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LEAD = 3'd1,
      PH_STRB = 3'd2,
      PH_HOLD = 3'd3,
      PH_GAP  = 3'd4,
      PH_TAIL = 3'd5
   } vlat_phase_e;

   // cycles between chip select falling and the first strobe
   localparam int unsigned LEAD_CYCLES = 2;
   // fixed addition to the programmed gap field
   localparam int unsigned GAP_EXTRA   = 2;
   // fixed addition to the programmed width field
   localparam int unsigned WIDTH_EXTRA = 1;

endpackage

// File: rtl/vlat_rdy_sync.sv
module vlat_rdy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("vlat_rdy_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/vlat_seq.sv
module vlat_seq
   import vlat_pkg::*;
#(
   parameter int unsigned CFG_W = 4,
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CFG_W-1:0] cfg_rdf,
   input  logic [CFG_W-1:0] cfg_rdn,
   input  logic [LEN_W-1:0] len,
   input  logic             rdy_s,
   output vlat_phase_e      phase,
   output logic             accept,
   output logic             capture,
   output logic             advance
);

   localparam int unsigned CNT_W = CFG_W + 1;

   if (CFG_W < 1) begin : g_bad_cfg
      $error("vlat_seq: CFG_W must be at least 1");
   end
   if (LEAD_CYCLES < 1) begin : g_bad_lead
      $error("vlat_seq: LEAD_CYCLES must be at least 1");
   end

   vlat_phase_e      phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CFG_W-1:0] rdf_q;
   logic [CFG_W-1:0] rdn_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] beat_q;

   logic width_ok;
   logic gap_done;
   logic lead_done;
   logic last_beat;

   assign width_ok  = cnt_q >= ({1'b0, rdf_q} + CNT_W'(WIDTH_EXTRA));
   assign gap_done  = cnt_q == ({1'b0, rdn_q} + CNT_W'(GAP_EXTRA));
   assign lead_done = cnt_q == CNT_W'(LEAD_CYCLES - 1);
   assign last_beat = beat_q == len_q;

   assign accept  = (phase_q == PH_IDLE) && start;
   assign capture = (phase_q == PH_STRB) && width_ok && rdy_s;
   assign advance = (phase_q == PH_HOLD) && !last_beat;
   assign phase   = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         rdf_q   <= '0;
         rdn_q   <= '0;
         len_q   <= '0;
         beat_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_LEAD;
                  cnt_q   <= '0;
                  rdf_q   <= cfg_rdf;
                  rdn_q   <= cfg_rdn;
                  len_q   <= len;
                  beat_q  <= '0;
               end
            end
            PH_LEAD: begin
               if (lead_done) begin
                  phase_q <= PH_STRB;
                  cnt_q   <= CNT_W'(1);
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_STRB: begin
               if (capture) begin
                  phase_q <= PH_HOLD;
               end else if (!(&cnt_q)) begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_HOLD: begin
               if (last_beat) begin
                  phase_q <= PH_TAIL;
               end else begin
                  phase_q <= PH_GAP;
                  cnt_q   <= CNT_W'(1);
                  beat_q  <= beat_q + LEN_W'(1);
               end
            end
            PH_GAP: begin
               if (gap_done) begin
                  phase_q <= PH_STRB;
                  cnt_q   <= CNT_W'(1);
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_TAIL: begin
               phase_q <= PH_IDLE;
            end
            default: begin
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/vlat_addr_gen.sv
module vlat_addr_gen #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned STEP   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              load_incr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("vlat_addr_gen: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              incr_q;

   if (STEP == 0) begin : g_fixed
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    addr_q <= '0;
         else if (load) addr_q <= load_addr;
      end
      assign incr_q = 1'b0;
   end else begin : g_stepping
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
            incr_q <= 1'b0;
         end else if (load) begin
            addr_q <= load_addr;
            incr_q <= load_incr;
         end else if (step && incr_q) begin
            addr_q <= addr_q + ADDR_W'(STEP);
         end
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/vlat_lane.sv
module vlat_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_en,
   input  logic [LANE_W-1:0] load_data,
   input  logic              active,
   input  logic              wr_mode,
   output logic              en,
   output logic [LANE_W-1:0] data,
   output logic              sel_n
);

   logic              en_q;
   logic [LANE_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         data_q <= '0;
      end else if (load) begin
         en_q   <= load_en;
         data_q <= load_data;
      end
   end

   assign en    = en_q;
   assign data  = data_q;
   assign sel_n = active ? (wr_mode ? !en_q : 1'b0) : 1'b1;

endmodule

// File: rtl/vlat_bus_ctrl.sv
module vlat_bus_ctrl
   import vlat_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MAX_BEATS   = 16,
   parameter int unsigned CFG_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEN_W       = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
   parameter int unsigned BE_W        = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_incr,
   input  logic [CFG_W-1:0]  cfg_rdf,
   input  logic [CFG_W-1:0]  cfg_rdn,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              bus_cs_n,
   output logic              bus_oe_n,
   output logic              bus_pwe_n,
   output logic [BE_W-1:0]   bus_bs_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wdata_en,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy
);

   localparam int unsigned LANE_W = 8;

   if (DATA_W % LANE_W != 0 || DATA_W == 0) begin : g_bad_data
      $error("vlat_bus_ctrl: DATA_W must be a non-zero multiple of 8");
   end
   if (MAX_BEATS < 2 || (MAX_BEATS & (MAX_BEATS - 1)) != 0) begin : g_bad_beats
      $error("vlat_bus_ctrl: MAX_BEATS must be a power of two >= 2");
   end
   if (LEN_W != $clog2(MAX_BEATS)) begin : g_bad_len
      $error("vlat_bus_ctrl: LEN_W must not be overridden");
   end

   vlat_phase_e phase;
   logic        accept;
   logic        capture;
   logic        advance;
   logic        rdy_s;
   logic        wr_q;
   logic        active;
   logic        strobe_on;
   logic [BE_W-1:0] lane_en;

   vlat_rdy_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (bus_rdy),
      .sync_out (rdy_s)
   );

   vlat_seq #(
      .CFG_W (CFG_W),
      .LEN_W (LEN_W)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (req_valid),
      .cfg_rdf (cfg_rdf),
      .cfg_rdn (cfg_rdn),
      .len     (req_len),
      .rdy_s   (rdy_s),
      .phase   (phase),
      .accept  (accept),
      .capture (capture),
      .advance (advance)
   );

   vlat_addr_gen #(
      .ADDR_W (ADDR_W),
      .STEP   (1)
   ) i_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (req_addr),
      .load_incr (req_incr),
      .step      (advance),
      .addr      (bus_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_q <= 1'b0;
      else if (accept) wr_q <= req_write;
   end

   assign wr_take   = (accept && req_write) || (advance && wr_q);
   assign active    = phase != PH_IDLE;
   assign strobe_on = (phase == PH_STRB) || (phase == PH_HOLD);

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      vlat_lane #(
         .LANE_W (LANE_W)
      ) i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (wr_take),
         .load_en   (wr_be[i]),
         .load_data (wr_data[i*LANE_W +: LANE_W]),
         .active    (active),
         .wr_mode   (wr_q),
         .en        (lane_en[i]),
         .data      (bus_wdata[i*LANE_W +: LANE_W]),
         .sel_n     (bus_bs_n[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= capture && !wr_q;
         if (capture && !wr_q) rd_data <= bus_rdata;
      end
   end

   assign busy         = active;
   assign bus_cs_n     = !active;
   assign bus_oe_n     = !(strobe_on && !wr_q);
   assign bus_pwe_n    = !(strobe_on && wr_q && (|lane_en));
   assign bus_wdata_en = active && wr_q;

endmodule

// File: rtl/vlat_bus_chk.sv
module vlat_bus_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  rd_valid,
   input logic                  cs_n,
   input logic                  oe_n,
   input logic                  pwe_n,
   input logic [DATA_W/8-1:0]   bs_n,
   input logic [ADDR_W-1:0]     addr
);

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (cs_n && oe_n && pwe_n && !busy && !rd_valid));

   // R3
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !pwe_n));

   // R3
   a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (oe_n && pwe_n));

   // R2
   a_r2_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (oe_n && pwe_n) ##1 (oe_n && pwe_n));

   // R8
   a_r8_tail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(oe_n && pwe_n));

   // R9
   a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && $past(!oe_n)) |-> $stable(addr));

   // R6
   a_r6_valid_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !oe_n);

   // R10
   a_r10_pwe_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !pwe_n |-> (bs_n != '1));

endmodule

bind vlat_bus_ctrl vlat_bus_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rd_valid (rd_valid),
   .cs_n     (bus_cs_n),
   .oe_n     (bus_oe_n),
   .pwe_n    (bus_pwe_n),
   .bs_n     (bus_bs_n),
   .addr     (bus_addr)
);

// File: tb/test_vlat_bus_ctrl.sv
module test_vlat_bus_ctrl;

   localparam int AW = 12;
   localparam int DW = 16;
   localparam int BW = DW / 8;
   localparam int MB = 8;
   localparam int LW = 3;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   always #5 clk = ~clk;

   logic          req_valid = 0, req_write = 0, req_incr = 0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [CW-1:0] cfg_rdf = '0, cfg_rdn = '0;
   logic [BW-1:0] wr_be;
   logic [DW-1:0] wr_data;
   logic          wr_take, busy, rd_valid;
   logic [DW-1:0] rd_data;
   logic          bus_cs_n, bus_oe_n, bus_pwe_n, bus_wdata_en;
   logic [BW-1:0] bus_bs_n;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;
   logic          bus_rdy = 1'b0;

   logic [BW-1:0] tb_be [MB];
   logic [DW-1:0] tb_dat [MB];
   int            wi = 0;
   assign wr_be   = tb_be[wi];
   assign wr_data = tb_dat[wi];

   vlat_bus_ctrl #(
      .ADDR_W (AW), .DATA_W (DW), .MAX_BEATS (MB), .CFG_W (CW), .SYNC_STAGES (2)
   ) i_vlat_bus_ctrl (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_len (req_len), .req_incr (req_incr),
      .cfg_rdf (cfg_rdf), .cfg_rdn (cfg_rdn), .wr_be (wr_be), .wr_data (wr_data),
      .wr_take (wr_take), .busy (busy), .rd_valid (rd_valid), .rd_data (rd_data),
      .bus_cs_n (bus_cs_n), .bus_oe_n (bus_oe_n), .bus_pwe_n (bus_pwe_n),
      .bus_bs_n (bus_bs_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_wdata_en (bus_wdata_en), .bus_rdata (bus_rdata), .bus_rdy (bus_rdy)
   );

   int tests = 0, fails = 0, cyc = 0, rdy_mode = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wrap_up();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // external side stimulus: data pattern and ready pattern
   always @(negedge clk) begin
      cyc <= cyc + 1;
      bus_rdata <= DW'(16'hA500 + cyc * 7);
      case (rdy_mode)
         0: bus_rdy <= 1'b1;
         1: bus_rdy <= ((cyc / 3) % 3) == 2;
         default: bus_rdy <= ((cyc % 11) > 6);
      endcase
   end

   always @(posedge clk) if (wr_take) wi <= wi + 1;

   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
         wrap_up();
      end
   end

   // behavioural reference model
   int            m_ph = 0, m_cnt = 0, m_beat = 0, m_len = 0, m_rdf = 0, m_rdn = 0;
   bit            m_wr = 0, m_incr = 0, m_rv = 0, m_s1 = 0, m_s2 = 0;
   int            m_addr = 0;
   logic [BW-1:0] m_be = '0;
   logic [DW-1:0] m_dat = '0, m_rd = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_s1 = 0; m_s2 = 0; m_rv = 0;
      end else begin
         bit rs;
         rs = m_s2; m_s2 = m_s1; m_s1 = bus_rdy;
         m_rv = 0;
         case (m_ph)
            0: if (req_valid) begin
               m_ph = 1; m_cnt = 0; m_wr = req_write; m_incr = req_incr;
               m_addr = int'(req_addr); m_len = int'(req_len); m_beat = 0;
               m_rdf = int'(cfg_rdf); m_rdn = int'(cfg_rdn);
               if (req_write) begin m_be = wr_be; m_dat = wr_data; end
            end
            1: if (m_cnt == 1) begin m_ph = 2; m_cnt = 1; end else m_cnt++;
            2: if (rs && m_cnt >= m_rdf + 1) begin
                  m_ph = 3;
                  if (!m_wr) begin m_rv = 1; m_rd = bus_rdata; end
               end else m_cnt++;
            3: if (m_beat == m_len) m_ph = 5;
               else begin
                  m_beat++; m_ph = 4; m_cnt = 1;
                  if (m_incr) m_addr = (m_addr + 1) % (1 << AW);
                  if (m_wr) begin m_be = wr_be; m_dat = wr_data; end
               end
            4: if (m_cnt == m_rdn + 2) begin m_ph = 2; m_cnt = 1; end else m_cnt++;
            default: m_ph = 0;
         endcase
      end
   end

   bit started = 0;
   always @(negedge clk) begin
      if (rst_n && started && !done) begin
         bit act, stb;
         act = m_ph != 0;
         stb = (m_ph == 2) || (m_ph == 3);
         chk(bus_cs_n == !act, "R8", "cs_n", bus_cs_n, !act);
         chk(busy == act, "R8", "busy", busy, act);
         chk(bus_oe_n == !(stb && !m_wr), "R3", "oe_n", bus_oe_n, !(stb && !m_wr));
         chk(bus_pwe_n == !(stb && m_wr && m_be != 0), "R10", "pwe_n",
             bus_pwe_n, !(stb && m_wr && m_be != 0));
         chk(rd_valid == m_rv, "R6", "rd_valid", rd_valid, m_rv);
         if (m_rv) chk(rd_data == m_rd, "R6", "rd_data", rd_data, m_rd);
         if (act) begin
            logic [BW-1:0] ebs;
            ebs = m_wr ? ~m_be : '0;
            chk(bus_bs_n == ebs, "R10", "bs_n", bus_bs_n, ebs);
            chk(int'(bus_addr) == m_addr, "R9", "addr", bus_addr, m_addr);
            chk(bus_wdata_en == m_wr, "R13", "wdata_en", bus_wdata_en, m_wr);
            if (m_wr) chk(bus_wdata == m_dat, "R13", "wdata", bus_wdata, m_dat);
         end else begin
            chk(bus_bs_n == '1, "R8", "bs_n idle", bus_bs_n, '1);
         end
      end
   end

   // strobe shape monitor
   int  lead, tail, lo_run, hi_run, lo_min, lo_max, gap_min, gap_max;
   int  oe_pulses, pwe_pulses, rv_count, cs_falls;
   bit  seen, prev_cs_n = 1;

   task automatic clear_stats();
      lead = -1; tail = -1; lo_run = 0; hi_run = 0; seen = 0;
      lo_min = 999; lo_max = 0; gap_min = 999; gap_max = 0;
      oe_pulses = 0; pwe_pulses = 0; rv_count = 0; cs_falls = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit stb;
         stb = !bus_oe_n || !bus_pwe_n;
         if (rd_valid) rv_count++;
         if (!bus_cs_n) begin
            if (prev_cs_n) begin cs_falls++; hi_run = 0; lo_run = 0; seen = 0; end
            if (stb) begin
               if (lo_run == 0) begin
                  if (!seen) lead = hi_run;
                  else begin
                     if (hi_run < gap_min) gap_min = hi_run;
                     if (hi_run > gap_max) gap_max = hi_run;
                  end
                  seen = 1;
                  if (!bus_oe_n) oe_pulses++; else pwe_pulses++;
               end
               lo_run++; hi_run = 0;
            end else begin
               if (lo_run > 0) begin
                  if (lo_run < lo_min) lo_min = lo_run;
                  if (lo_run > lo_max) lo_max = lo_run;
                  lo_run = 0;
               end
               hi_run++;
            end
         end else if (!prev_cs_n) begin
            tail = hi_run;
         end
         prev_cs_n = bus_cs_n;
      end
   end

   task automatic run_burst(input bit wr, input int addr, input int beats, input bit incr,
                            input int rdf, input int rdn, input int mode, input bit poke);
      @(negedge clk); #1;
      clear_stats();
      wi = 0; rdy_mode = mode;
      req_valid = 1; req_write = wr; req_addr = AW'(addr); req_len = LW'(beats - 1);
      req_incr = incr; cfg_rdf = CW'(rdf); cfg_rdn = CW'(rdn);
      @(negedge clk); #1;
      req_valid = 0;
      if (poke) begin
         repeat (5) @(negedge clk);
         #1;
         req_valid = 1; req_addr = AW'(addr + 16); req_write = !wr;
         cfg_rdf = CW'(15); cfg_rdn = CW'(15);
         @(negedge clk); #1;
         req_valid = 0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < MB; i++) begin tb_be[i] = '1; tb_dat[i] = DW'(16'h1100 * (i + 1)); end
      #2 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: quiet outputs in reset
      chk(bus_cs_n && bus_oe_n && bus_pwe_n, "R1", "strobes in reset",
          {bus_cs_n, bus_oe_n, bus_pwe_n}, 3'b111);
      chk(bus_bs_n == '1 && !busy && !rd_valid, "R1", "bs/busy/valid in reset",
          {bus_bs_n, busy, rd_valid}, {BW'('1), 2'b00});
      #1 rst_n = 1'b1;
      started = 1;
      repeat (4) @(negedge clk);

      // read burst, 4 beats, incrementing, ready early
      run_burst(0, 'h010, 4, 1, 2, 1, 0, 0);
      chk(lead == 2, "R2", "lead cycles", lead, 2);
      chk(lo_min == 4 && lo_max == 4, "R5", "oe width", lo_max, 4);
      chk(gap_min == 3 && gap_max == 3, "R7", "gap width", gap_max, 3);
      chk(tail == 1, "R8", "tail cycles", tail, 1);
      chk(oe_pulses == 4 && pwe_pulses == 0, "R3", "read pulses", oe_pulses, 4);
      chk(rv_count == 4, "R6", "read beats", rv_count, 4);

      // write burst with a fully masked beat, fixed address, request and cfg poked mid-burst
      tb_be[0] = 2'b11; tb_be[1] = 2'b00; tb_be[2] = 2'b01;
      run_burst(1, 'h0FF, 3, 0, 1, 0, 0, 1);
      chk(pwe_pulses == 2 && oe_pulses == 0, "R10", "masked beat strobes", pwe_pulses, 2);
      chk(cs_falls == 1, "R12", "cs assertions", cs_falls, 1);
      chk(lo_min == 3 && lo_max == 3, "R11", "width from sampled rdf", lo_max, 3);
      chk(rv_count == 0, "R6", "no read valid on write", rv_count, 0);

      // read burst across the top of the address space, slow ready
      for (int i = 0; i < MB; i++) tb_be[i] = '1;
      run_burst(0, 'hFFE, 3, 1, 0, 0, 1, 0);
      chk(rv_count == 3, "R4", "slow ready beats", rv_count, 3);
      chk(lo_min >= 2, "R5", "minimum oe width", lo_min, 2);
      chk(gap_min == 2, "R7", "gap with rdn 0", gap_min, 2);

      // single read beat, extreme fields
      run_burst(0, 'h123, 1, 1, 15, 15, 0, 0);
      chk(lo_min == 17, "R5", "oe width at rdf 15", lo_min, 17);
      chk(lead == 2 && tail == 1, "R8", "lead/tail single", tail, 1);

      // write burst with irregular ready
      tb_be[0] = 2'b01; tb_be[1] = 2'b10;
      run_burst(1, 'h200, 2, 1, 3, 2, 2, 0);
      chk(pwe_pulses == 2, "R13", "write beats", pwe_pulses, 2);
      chk(gap_min >= 4, "R7", "gap at rdn 2", gap_min, 4);

      done = 1;
      wrap_up();
   end

endmodule